// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block is a read-only instruction cache that sits between a processor fetch port and slower external memory. Its storage holds 4 Kbytes of instruction words in two ways of 128 lines each, and every line holds four words. A fetch that hits returns its word one cycle after it is accepted. A fetch that misses reads the whole line from external memory in four sequential beats, stores the line in a victim way and then returns the requested word. External beats use a request/ready handshake, so memory can insert wait cycles.

Software controls the block through a small write-only register port. Through this port it can enable or disable allocation on misses and flush every unlocked line in one step. It can also lock or unlock any line, which keeps resident code from being evicted. A half-size mode reduces the cache to 2 Kbytes, using way 0 only as a direct-mapped cache. In that mode the way-1 storage becomes a directly addressed instruction RAM window, and software loads it through a pointer and a data register.

Top module: `icache_lock2w`

## Requirements
- R1: A fetch whose line is valid in an active way returns the stored word with fetchHit=1 on the cycle after acceptance and makes no external request.
- R2: With allocation enabled, a miss on a line that has an unlocked victim way reads four beats at line base + 0, 4, 8, 12 in that order. Each beat address is held until memRdy is high. The block then returns the requested word with fetchHit=0, and later fetches of any word of that line hit.
- R3: The byte address is split into word-in-line bits [3:2], set index bits [10:4] and tag bits [31:11]. Two lines with the same set and different tags can be resident at the same time.
- R4: Each set keeps one replacement bit, which is updated on every hit and every fill. When neither way is locked, a miss replaces the way used least recently.
- R5: A locked line is never chosen as the victim. A miss in a set with one locked way replaces the other way.
- R6: A miss in a set with no unlocked active way performs a single external read of the fetch address, returns that word with fetchHit=0, and leaves the cache contents unchanged.
- R7: A control write (select 0) with bit 2 set invalidates every unlocked line in one cycle. Locked lines stay valid and keep hitting.
- R8: When control bit 0 (allocation enable) is 0, hits are still served, and misses become single-word external reads that allocate nothing.
- R9: When control bit 1 (half size) is 1, only way 0 caches code. Fetches whose tag bits equal those of the RAM window base (0x0001_0000) return way-1 storage word (address bits [10:2]) with fetchHit=1 and no external access.
- R10: Select 2 loads the RAM pointer from bits [8:0]. Each select-3 write stores its data at the pointer and increments the pointer, but only in half-size mode. In full-size mode the write is ignored.
- R11: After reset no line is valid, allocation is enabled, full-size mode is selected, and fetchValid and memReq are low while fetchRdy and cfgRdy are high.
- R12: Select 1 sets or clears the lock bit of one line: bits [6:0] give the set, bit 8 the way, and bit 9 the new lock value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReq | input | 1 | Fetch request |
| fetchAddr | input | 32 | Fetch byte address |
| fetchRdy | output | 1 | Fetch accepted when high together with fetchReq |
| fetchValid | output | 1 | One-cycle response strobe |
| fetchData | output | 32 | Returned instruction word |
| fetchHit | output | 1 | Response was served from on-chip storage |
| memReq | output | 1 | External read beat requested |
| memAddr | output | 32 | External byte address of the current beat |
| memRdy | input | 1 | External beat completes this cycle |
| memData | input | 32 | External read data |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 control, 1 lock, 2 RAM pointer, 3 RAM data |
| cfgData | input | 32 | Register write data |
| cfgRdy | output | 1 | Register write accepted when high |

## Verification
Any wrong tag, valid, lock or replacement bit first shows up on the next fetch to the affected set. It appears as a changed hit flag and a changed count of external beats on that response, or as a wrong word at the fetch port. The bench therefore fixes every fetch's expected hit flag, beat count and data from the access history. Each scenario also ends with follow-up fetches that reveal which line each way holds. A stale way-1 line in half-size mode, or a RAM write that leaks through in full-size mode, shows up as wrong data on the next fetch in the RAM window.

// File: rtl/icache_pkg.sv
package icache_pkg;
  parameter int ADDR_W = 32;
  parameter int WORD_W = 32;
  parameter int SET_W  = 7;
  parameter int LW_W   = 2;

  localparam int BYTE_W       = $clog2(WORD_W / 8);
  localparam int SETS         = 1 << SET_W;
  localparam int LINE_WORDS   = 1 << LW_W;
  localparam int IDX_W        = SET_W + LW_W;
  localparam int TAG_W        = ADDR_W - IDX_W - BYTE_W;
  localparam int LOCK_WAY_BIT = SET_W + 1;
  localparam int LOCK_VAL_BIT = SET_W + 2;
  localparam logic [LW_W-1:0] LAST_BEAT = LW_W'(LINE_WORDS - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BYPASS
  } ctlState_t;

  typedef struct packed {
    logic              lineWe;
    logic              lineWay;
    logic [SET_W-1:0]  lineSet;
    logic [LW_W-1:0]   lineWord;
    logic [WORD_W-1:0] lineData;
    logic              tagWe;
    logic [TAG_W-1:0]  tagVal;
    logic              lruWe;
    logic              lruWay;
    logic [SET_W-1:0]  lruSet;
    logic              flush;
    logic              dropWay1;
    logic              lockWe;
    logic              lockWay;
    logic [SET_W-1:0]  lockSet;
    logic              lockVal;
    logic              ramWe;
    logic [IDX_W-1:0]  ramIdx;
    logic [WORD_W-1:0] ramData;
  } dpCtl_t;
endpackage

// File: rtl/icache_dp.sv
module icache_dp
  import icache_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic [SET_W-1:0]       lookSet,
  input  logic [LW_W-1:0]        lookWord,
  input  logic [TAG_W-1:0]       lookTag,
  output logic [1:0]             hitWay,
  output logic [1:0]             lockBits,
  output logic                   lruBit,
  output logic [1:0][WORD_W-1:0] rdWord
);

  // One replacement bit per set: holds the way to replace next.
  logic [SETS-1:0] lruVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lruVec <= '0;
    end else if (ctl.lruWe) begin
      lruVec[ctl.lruSet] <= ~ctl.lruWay;
    end
  end

  assign lruBit = lruVec[lookSet];

  for (genvar w = 0; w < 2; w++) begin : g_way
    localparam bit IS_RAM_WAY = (w == 1);

    logic [WORD_W-1:0] dataMem [SETS*LINE_WORDS];
    logic [TAG_W-1:0]  tagMem  [SETS];
    logic [SETS-1:0]   validW;
    logic [SETS-1:0]   lockW;
    logic              fillHere;
    logic              tagHere;
    logic              ramHere;

    assign fillHere = ctl.lineWe && (ctl.lineWay == 1'(w));
    assign tagHere  = ctl.tagWe && (ctl.lineWay == 1'(w));
    assign ramHere  = IS_RAM_WAY && ctl.ramWe;

    always_ff @(posedge clk) begin
      if (fillHere) begin
        dataMem[{ctl.lineSet, ctl.lineWord}] <= ctl.lineData;
      end else if (ramHere) begin
        dataMem[ctl.ramIdx] <= ctl.ramData;
      end
      if (tagHere) begin
        tagMem[ctl.lineSet] <= ctl.tagVal;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validW <= '0;
        lockW  <= '0;
      end else begin
        if (ctl.flush) begin
          validW <= validW & lockW;
        end else if (IS_RAM_WAY && ctl.dropWay1) begin
          validW <= '0;
        end else if (tagHere) begin
          validW[ctl.lineSet] <= 1'b1;
        end
        if (ctl.lockWe && (ctl.lockWay == 1'(w))) begin
          lockW[ctl.lockSet] <= ctl.lockVal;
        end
      end
    end

    assign hitWay[w]   = validW[lookSet] && (tagMem[lookSet] == lookTag);
    assign lockBits[w] = lockW[lookSet];
    assign rdWord[w]   = dataMem[{lookSet, lookWord}];

    // A fill beat must never land in a locked line.
    assert_no_locked_fill_R5 : assert property (@(posedge clk) disable iff (!rstN)
      fillHere |-> !lockW[ctl.lineSet]);

    // After a flush only locked lines may remain valid.
    assert_flush_keeps_locked_R7 : assert property (@(posedge clk) disable iff (!rstN)
      ctl.flush |=> ((validW & ~lockW) == '0));
  end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h0001_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fetchReq,
  input  logic [ADDR_W-1:0]      fetchAddr,
  output logic                   fetchRdy,
  output logic                   fetchValid,
  output logic [WORD_W-1:0]      fetchData,
  output logic                   fetchHit,
  output logic                   memReq,
  output logic [ADDR_W-1:0]      memAddr,
  input  logic                   memRdy,
  input  logic [WORD_W-1:0]      memData,
  input  logic                   cfgWe,
  input  logic [1:0]             cfgSel,
  input  logic [WORD_W-1:0]      cfgData,
  output logic                   cfgRdy,
  input  logic [1:0]             hitWay,
  input  logic [1:0]             lockBits,
  input  logic                   lruBit,
  input  logic [1:0][WORD_W-1:0] rdWord,
  output dpCtl_t                 ctl
);

  ctlState_t         state;
  logic [ADDR_W-1:0] reqAddr;
  logic              allocWay;
  logic [LW_W-1:0]   beat;
  logic [WORD_W-1:0] capData;
  logic              respValid;
  logic [WORD_W-1:0] respData;
  logic              respHit;
  logic              fillEn;
  logic              halfSize;
  logic [IDX_W-1:0]  ramPtr;

  logic              isIdle;
  logic              accept;
  logic              cfgTake;
  logic              inRam;
  logic [1:0]        waysOn;
  logic [1:0]        hitMask;
  logic              anyHit;
  logic              hitSel;
  logic [1:0]        freeMask;
  logic              canAlloc;
  logic              victimWay;
  logic [SET_W-1:0]  reqSet;
  logic [LW_W-1:0]   reqWord;
  logic [TAG_W-1:0]  reqTag;
  logic              lastBeat;

  assign isIdle   = (state == ST_IDLE);
  assign cfgRdy   = isIdle;
  assign fetchRdy = isIdle && !cfgWe;
  assign accept   = fetchReq && fetchRdy;
  assign cfgTake  = cfgWe && isIdle;

  assign inRam    = halfSize && (fetchAddr[ADDR_W-1 -: TAG_W] == RAM_BASE[ADDR_W-1 -: TAG_W]);
  assign waysOn   = {~halfSize, 1'b1};
  assign hitMask  = hitWay & waysOn;
  assign anyHit   = |hitMask;
  assign hitSel   = hitMask[1];
  assign freeMask = ~lockBits & waysOn;
  assign canAlloc = |freeMask;
  assign victimWay = (freeMask == 2'b11) ? lruBit : freeMask[1];

  assign reqSet   = reqAddr[BYTE_W+LW_W +: SET_W];
  assign reqWord  = reqAddr[BYTE_W +: LW_W];
  assign reqTag   = reqAddr[ADDR_W-1 -: TAG_W];
  assign lastBeat = (beat == LAST_BEAT);

  assign memReq  = !isIdle;
  assign memAddr = (state == ST_FILL)
                 ? {reqAddr[ADDR_W-1:LW_W+BYTE_W], beat, {BYTE_W{1'b0}}}
                 : reqAddr;

  assign fetchValid = respValid;
  assign fetchData  = respData;
  assign fetchHit   = respHit;

  // Strobes towards the storage arrays.
  always_comb begin
    ctl          = '0;
    ctl.lineWay  = allocWay;
    ctl.lineSet  = reqSet;
    ctl.lineWord = beat;
    ctl.lineData = memData;
    ctl.tagVal   = reqTag;
    ctl.lineWe   = (state == ST_FILL) && memRdy;
    ctl.tagWe    = ctl.lineWe && lastBeat;
    if (accept && !inRam && anyHit) begin
      ctl.lruWe  = 1'b1;
      ctl.lruSet = fetchAddr[BYTE_W+LW_W +: SET_W];
      ctl.lruWay = hitSel;
    end else if (ctl.tagWe) begin
      ctl.lruWe  = 1'b1;
      ctl.lruSet = reqSet;
      ctl.lruWay = allocWay;
    end
    ctl.lockSet = cfgData[SET_W-1:0];
    ctl.lockWay = cfgData[LOCK_WAY_BIT];
    ctl.lockVal = cfgData[LOCK_VAL_BIT];
    ctl.ramIdx  = ramPtr;
    ctl.ramData = cfgData;
    if (cfgTake) begin
      case (cfgSel)
        2'd0: begin
          ctl.flush    = cfgData[2];
          ctl.dropWay1 = cfgData[1] && !halfSize;
        end
        2'd1:    ctl.lockWe = 1'b1;
        2'd3:    ctl.ramWe  = halfSize;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      reqAddr   <= '0;
      allocWay  <= 1'b0;
      beat      <= '0;
      capData   <= '0;
      respValid <= 1'b0;
      respData  <= '0;
      respHit   <= 1'b0;
      fillEn    <= 1'b1;
      halfSize  <= 1'b0;
      ramPtr    <= '0;
    end else begin
      respValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cfgTake) begin
            case (cfgSel)
              2'd0: begin
                fillEn   <= cfgData[0];
                halfSize <= cfgData[1];
              end
              2'd2: ramPtr <= cfgData[IDX_W-1:0];
              2'd3: if (halfSize) ramPtr <= ramPtr + 1'b1;
              default: ;
            endcase
          end else if (accept) begin
            reqAddr <= fetchAddr;
            if (inRam) begin
              respValid <= 1'b1;
              respData  <= rdWord[1];
              respHit   <= 1'b1;
            end else if (anyHit) begin
              respValid <= 1'b1;
              respData  <= rdWord[hitSel];
              respHit   <= 1'b1;
            end else if (fillEn && canAlloc) begin
              state    <= ST_FILL;
              allocWay <= victimWay;
              beat     <= '0;
            end else begin
              state <= ST_BYPASS;
            end
          end
        end
        ST_FILL: begin
          if (memRdy) begin
            beat <= beat + 1'b1;
            if (beat == reqWord) capData <= memData;
            if (lastBeat) begin
              state     <= ST_IDLE;
              respValid <= 1'b1;
              respHit   <= 1'b0;
              respData  <= (reqWord == LAST_BEAT) ? memData : capData;
            end
          end
        end
        ST_BYPASS: begin
          if (memRdy) begin
            state     <= ST_IDLE;
            respValid <= 1'b1;
            respHit   <= 1'b0;
            respData  <= memData;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // A hit is answered next cycle without touching external memory.
  assert_hit_no_mem_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (accept && anyHit && !inRam) |=> (fetchValid && fetchHit && !memReq));

  // External beat address holds while memory stalls.
  assert_mem_addr_hold_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memAddr)));

  // In half-size mode fills only target way 0.
  assert_half_way0_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineWe && halfSize) |-> !ctl.lineWay);

  // RAM window fetches are local hits.
  assert_ram_local_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (accept && inRam) |=> (fetchValid && fetchHit && !memReq));

endmodule

// File: rtl/icache_lock2w.sv
module icache_lock2w
  import icache_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchRdy,
  output logic              fetchValid,
  output logic [WORD_W-1:0] fetchData,
  output logic              fetchHit,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdy,
  input  logic [WORD_W-1:0] memData,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [WORD_W-1:0] cfgData,
  output logic              cfgRdy
);

  dpCtl_t                 ctl;
  logic [1:0]             hitWay;
  logic [1:0]             lockBits;
  logic                   lruBit;
  logic [1:0][WORD_W-1:0] rdWord;

  icache_ctrl #(.RAM_BASE(RAM_BASE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchReq   (fetchReq),
    .fetchAddr  (fetchAddr),
    .fetchRdy   (fetchRdy),
    .fetchValid (fetchValid),
    .fetchData  (fetchData),
    .fetchHit   (fetchHit),
    .memReq     (memReq),
    .memAddr    (memAddr),
    .memRdy     (memRdy),
    .memData    (memData),
    .cfgWe      (cfgWe),
    .cfgSel     (cfgSel),
    .cfgData    (cfgData),
    .cfgRdy     (cfgRdy),
    .hitWay     (hitWay),
    .lockBits   (lockBits),
    .lruBit     (lruBit),
    .rdWord     (rdWord),
    .ctl        (ctl)
  );

  icache_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .lookSet  (fetchAddr[BYTE_W+LW_W +: SET_W]),
    .lookWord (fetchAddr[BYTE_W +: LW_W]),
    .lookTag  (fetchAddr[ADDR_W-1 -: TAG_W]),
    .hitWay   (hitWay),
    .lockBits (lockBits),
    .lruBit   (lruBit),
    .rdWord   (rdWord)
  );

endmodule

// File: tb/sim_icache_lock2w.sv
module sim_icache_lock2w;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RAMB = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchRdy, fetchValid, fetchHit;
  logic [31:0] fetchData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRdy = 1'b1;
  logic [31:0] memData;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        cfgRdy;

  int nChecks = 0;
  int nErr = 0;
  int beatCnt = 0;
  logic [31:0] beatLog [0:63];
  logic stallOn = 1'b0;
  logic [3:0] stallCnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_5A5A;
  endfunction

  assign memData = memFn(memAddr);

  always @(negedge clk) begin
    stallCnt <= stallCnt + 1'b1;
    memRdy   <= stallOn ? stallCnt[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (rstN && memReq && memRdy) begin
      beatLog[beatCnt % 64] = memAddr;
      beatCnt = beatCnt + 1;
    end
  end

  icache_lock2w u0 (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchRdy(fetchRdy), .fetchValid(fetchValid), .fetchData(fetchData),
    .fetchHit(fetchHit), .memReq(memReq), .memAddr(memAddr), .memRdy(memRdy),
    .memData(memData), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .cfgRdy(cfgRdy)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    while (!cfgRdy) @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [31:0] lockCmd(input int set, input int way, input int val);
    return 32'(set) | (32'(way) << 8) | (32'(val) << 9);
  endfunction

  task automatic doFetch(input logic [31:0] addr, input logic expHit, input int expBeats,
                         input logic [31:0] expData, input string rq);
    int b0;
    int waitN;
    b0 = beatCnt;
    waitN = 0;
    @(negedge clk);
    fetchAddr = addr; fetchReq = 1'b1;
    while (!fetchRdy) @(negedge clk);
    @(negedge clk);
    fetchReq = 1'b0;
    while (!fetchValid && waitN < 200) begin
      @(negedge clk);
      waitN++;
    end
    check(fetchValid, {rq, " response"}, 32'(fetchValid), 32'd1);
    check(fetchData == expData, {rq, " data"}, fetchData, expData);
    check(fetchHit == expHit, {rq, " hit flag"}, 32'(fetchHit), 32'(expHit));
    check(beatCnt - b0 == expBeats, {rq, " beats"}, 32'(beatCnt - b0), 32'(expBeats));
    if (expHit) check(waitN == 0, {rq, " hit latency"}, 32'(waitN), 32'd0);
  endtask

  // R11: reset state
  task automatic tReset();
    check(!fetchValid, "R11 fetchValid", 32'(fetchValid), 0);
    check(!memReq, "R11 memReq", 32'(memReq), 0);
    check(fetchRdy, "R11 fetchRdy", 32'(fetchRdy), 1);
    check(cfgRdy, "R11 cfgRdy", 32'(cfgRdy), 1);
  endtask

  // R1 R2 R3 R4: fills, hits, two tags in one set, replacement order
  task automatic tFillAndLru();
    logic [31:0] a, b, c;
    int b0;
    a = 32'h0000_2054; b = a + 32'h800; c = a + 32'h1000;
    b0 = beatCnt;
    doFetch(a, 0, 4, memFn(a), "R2 first miss");
    for (int i = 0; i < 4; i++)
      check(beatLog[(b0 + i) % 64] == 32'h2050 + 32'(4 * i), "R2 beat order",
            beatLog[(b0 + i) % 64], 32'h2050 + 32'(4 * i));
    doFetch(32'h0000_205C, 1, 0, memFn(32'h205C), "R1 hit same line");
    doFetch(b, 0, 4, memFn(b), "R3 second tag miss");
    doFetch(a, 1, 0, memFn(a), "R3 first tag resident");
    doFetch(b, 1, 0, memFn(b), "R3 second tag resident");
    doFetch(c, 0, 4, memFn(c), "R4 third tag miss");
    doFetch(b, 1, 0, memFn(b), "R4 recent way kept");
    doFetch(a, 0, 4, memFn(a), "R4 lru way evicted");
    doFetch(b, 1, 0, memFn(b), "R4 recent way still kept");
  endtask

  // R2 with external wait cycles
  task automatic tStall();
    logic [31:0] p;
    int b0;
    p = 32'h0000_A30C;
    stallOn = 1'b1;
    b0 = beatCnt;
    doFetch(p, 0, 4, memFn(p), "R2 stalled fill");
    for (int i = 0; i < 4; i++)
      check(beatLog[(b0 + i) % 64] == 32'hA300 + 32'(4 * i), "R2 stalled beat order",
            beatLog[(b0 + i) % 64], 32'hA300 + 32'(4 * i));
    stallOn = 1'b0;
    doFetch(32'h0000_A300, 1, 0, memFn(32'hA300), "R2 stalled line hits");
  endtask

  // R5 R6 R12: locking
  task automatic tLock();
    logic [31:0] d, e, f, g;
    d = 32'h0000_4090; e = d + 32'h800; f = d + 32'h1000; g = d + 32'h1800;
    doFetch(d, 0, 4, memFn(d), "R5 fill way0");
    cfgWrite(2'd1, lockCmd(9, 0, 1));
    doFetch(e, 0, 4, memFn(e), "R5 fill way1");
    doFetch(e, 1, 0, memFn(e), "R5 way1 hit");
    doFetch(f, 0, 4, memFn(f), "R5 miss avoids locked");
    doFetch(d, 1, 0, memFn(d), "R12 locked line kept");
    doFetch(e, 0, 4, memFn(e), "R5 unlocked way replaced");
    cfgWrite(2'd1, lockCmd(9, 1, 1));
    doFetch(g, 0, 1, memFn(g), "R6 both locked bypass");
    doFetch(g, 0, 1, memFn(g), "R6 no allocation");
    doFetch(d, 1, 0, memFn(d), "R6 way0 unchanged");
    doFetch(e, 1, 0, memFn(e), "R6 way1 unchanged");
  endtask

  // R7: flush keeps locked lines
  task automatic tFlush();
    cfgWrite(2'd0, 32'h5);
    doFetch(32'h0000_4090, 1, 0, memFn(32'h4090), "R7 locked survives");
    doFetch(32'h0000_4890, 1, 0, memFn(32'h4890), "R7 locked way1 survives");
    doFetch(32'h0000_2054, 0, 4, memFn(32'h2054), "R7 unlocked flushed");
    doFetch(32'h0000_A300, 0, 4, memFn(32'hA300), "R7 other set flushed");
    cfgWrite(2'd1, lockCmd(9, 0, 0));
    cfgWrite(2'd1, lockCmd(9, 1, 0));
    doFetch(32'h0000_5890, 0, 4, memFn(32'h5890), "R12 unlock allows fill");
  endtask

  // R8: allocation disabled
  task automatic tNoFill();
    cfgWrite(2'd0, 32'h0);
    doFetch(32'h0000_2054, 1, 0, memFn(32'h2054), "R8 hit served");
    doFetch(32'h0000_6140, 0, 1, memFn(32'h6140), "R8 miss bypass");
    doFetch(32'h0000_6140, 0, 1, memFn(32'h6140), "R8 nothing allocated");
    cfgWrite(2'd0, 32'h1);
    doFetch(32'h0000_6140, 0, 4, memFn(32'h6140), "R8 fill resumes");
  endtask

  // R9 R10: half size and RAM window
  task automatic tHalf();
    logic [31:0] j, k;
    j = 32'h0000_81E0; k = j + 32'h800;
    cfgWrite(2'd0, 32'h3);
    cfgWrite(2'd2, 32'h10);
    cfgWrite(2'd3, 32'hCAFE_0001);
    cfgWrite(2'd3, 32'hCAFE_0002);
    cfgWrite(2'd3, 32'hCAFE_0003);
    doFetch(RAMB + 32'h40, 1, 0, 32'hCAFE_0001, "R10 ram word0");
    doFetch(RAMB + 32'h44, 1, 0, 32'hCAFE_0002, "R10 ram word1");
    doFetch(RAMB + 32'h48, 1, 0, 32'hCAFE_0003, "R9 ram word2");
    doFetch(j, 0, 4, memFn(j), "R9 half fill");
    doFetch(k, 0, 4, memFn(k), "R9 half conflict");
    doFetch(j, 0, 4, memFn(j), "R9 direct mapped evicted");
    cfgWrite(2'd0, 32'h1);
    cfgWrite(2'd2, 32'h10);
    cfgWrite(2'd3, 32'hDEAD_BEEF);
    cfgWrite(2'd0, 32'h3);
    doFetch(RAMB + 32'h40, 1, 0, 32'hCAFE_0001, "R10 full mode write ignored");
    cfgWrite(2'd0, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFillAndLru();
    tStall();
    tLock();
    tFlush();
    tNoFill();
    tHalf();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule